// File: doc/BRIEF.md
# Memory Access Attribute Resolver

This block sits beside a processor core's load/store and fetch paths and labels every memory request with the attributes that the memory system needs: a cache mode, a write-protect bit, a local-memory enable and a fault flag. It has a set of programmable windows. Each window is a base address, an address mask and a valid bit. There are two local RAM windows, two local ROM windows, four access-control windows, and an optional MMU register window. Default attributes cover requests that hit no window. The address itself is never altered. It is only carried to the output next to its attributes.

The lookup is combinational. The result is captured one clock after a request is presented. A two-state controller tracks whether the output registers hold a fresh result. The states are `ST_IDLE` (no result this cycle) and `ST_PRESENT` (a result is on the outputs). The transition `idle_to_present` fires when `req_valid` is high in `ST_IDLE`. The transition `present_stay` fires when another request arrives in `ST_PRESENT`. The transition `present_to_idle` fires when no request follows. The attribute registers are written only on a request, so a result stays visible until the next one.

The window to use follows a fixed priority that depends on the access kind. Data and instruction requests use different access-control windows. Special-class requests have forced attributes. Test-and-set data gets implied attributes. The MMU window is above all others for data.

Top module: `attr_resolver`

## Requirements
- R1: A normal data request selects the first matching window in this order: MMU window (only when present and enabled), RAM0, RAM1, ROM0, ROM1, ACR0, ACR1. `res_hit` is one-hot with bit 0 = MMU, bits 1-2 = RAM0/RAM1, bits 3-4 = ROM0/ROM1, bits 5-8 = ACR0..ACR3.
- R2: A normal instruction request uses the order RAM0, RAM1, ROM0, ROM1, ACR2, ACR3. It never selects ACR0, ACR1 or the MMU window.
- R3: With no eligible match, `res_cmode` = `def_cmode`, `res_wp` = `def_wp` and `res_hit` = 0.
- R4: A window matches when its valid bit is set and `(addr & mask) == (base & mask)`. A cleared valid bit removes the window from the lookup.
- R5: `req_class` encodes 00 normal, 01 interrupt acknowledge, 10 emulator, 11 other special (control register or cache command). Any non-zero class gives `res_cmode` = 10, `res_wp` = 0 and no fault. Only classes 01 and 10 may hit the RAM/ROM windows. Special requests never hit the ACR or MMU windows.
- R6: When `iack_mask` is 1, class 01 and 10 requests hit no window. Normal requests are unaffected.
- R7: A normal data request with `req_tas` = 1 that selects neither RAM window gets `res_cmode` = 10. Its write-protect result is unchanged. `req_tas` has no effect on instruction requests.
- R8: Cache mode encoding: 00 copyback, 01 write-through, 10 non-cacheable precise, 11 non-cacheable imprecise. A hit in the MMU, RAM or ROM windows gives `res_cmode` = 10. The MMU window is active only when the parameter `MMU_PRESENT` is 1 and `mmu_en` is 1. An MMU hit gives `res_wp` = 0 and `res_local_en` = 0.
- R9: A user-mode request (`req_super` = 0) that hits the MMU window sets `res_fault`.
- R10: RAM window i takes its write-protect bit from `ram_wp[i]`. ROM windows are always write-protected. ACR window i uses `acr_wp[i]` and `acr_cmode[2i+1:2i]`. A write whose result has `res_wp` = 1 sets `res_fault`. A read of the same region does not.
- R11: `res_local_en` is 1 exactly when a RAM or ROM window was selected and `res_fault` is 0.
- R12: The outputs are registered. `res_valid` is high in the cycle after `req_valid`. The other outputs hold their values while no request arrives. After reset, all outputs are 0.
- R13: `res_addr` equals the request address captured with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data |
| req_write | input | 1 | 1 = write |
| req_class | input | 2 | Access class (R5) |
| req_super | input | 1 | Supervisor mode |
| req_tas | input | 1 | Test-and-set request |
| ram_base | input | 2*AW | RAM window bases, window i at [i*AW +: AW] |
| ram_mask | input | 2*AW | RAM window masks |
| ram_valid | input | 2 | RAM window valid bits |
| ram_wp | input | 2 | RAM window write protect |
| rom_base | input | 2*AW | ROM window bases |
| rom_mask | input | 2*AW | ROM window masks |
| rom_valid | input | 2 | ROM window valid bits |
| acr_base | input | 4*AW | Access-control window bases |
| acr_mask | input | 4*AW | Access-control window masks |
| acr_valid | input | 4 | Access-control window valid bits |
| acr_cmode | input | 8 | Cache mode per access-control window |
| acr_wp | input | 4 | Write protect per access-control window |
| mmu_en | input | 1 | MMU window enable |
| mmu_base | input | AW | MMU window base |
| mmu_mask | input | AW | MMU window mask |
| iack_mask | input | 1 | Blocks interrupt-ack/emulator hits on RAM/ROM |
| def_cmode | input | 2 | Default cache mode |
| def_wp | input | 1 | Default write protect |
| res_valid | output | 1 | Result present |
| res_addr | output | AW | Request address, unchanged |
| res_cmode | output | 2 | Resolved cache mode |
| res_wp | output | 1 | Resolved write protect |
| res_hit | output | 9 | One-hot selected window |
| res_fault | output | 1 | Access fault |
| res_local_en | output | 1 | Local RAM/ROM enable |

## Verification
The windows are laid out so that they overlap in pairs: the MMU window lies inside RAM0, RAM0 inside RAM1, ROM0 inside ROM1, and ACR0 inside ACR1. An address in an overlap shows whether the higher-priority window wins. The same address is then sent as data and as an instruction, which shows the two ACR orderings apart. Each special class is tried on RAM and ROM addresses. Test-and-set is tried on both protected and unprotected windows, which separates the forced cache mode from the write-protect result that is kept. Directed runs toggle `iack_mask`, `mmu_en` and one valid bit, so that each gate is seen to open and to close.

// File: rtl/attr_pkg.sv
package attr_pkg;

    localparam int N_RAM = 2;
    localparam int N_ROM = 2;
    localparam int N_ACR = 4;
    localparam int NWIN  = 1 + N_RAM + N_ROM + N_ACR;

    localparam int IDX_MMU  = 0;
    localparam int IDX_RAM0 = 1;
    localparam int IDX_ROM0 = IDX_RAM0 + N_RAM;
    localparam int IDX_ACR0 = IDX_ROM0 + N_ROM;

    localparam logic [1:0] CM_COPYBACK   = 2'b00;
    localparam logic [1:0] CM_WTHRU      = 2'b01;
    localparam logic [1:0] CM_NC_PRECISE = 2'b10;
    localparam logic [1:0] CM_NC_IMPREC  = 2'b11;

    localparam logic [1:0] CLS_NORMAL = 2'b00;
    localparam logic [1:0] CLS_IACK   = 2'b01;
    localparam logic [1:0] CLS_EMU    = 2'b10;
    localparam logic [1:0] CLS_CTRL   = 2'b11;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } res_state_e;

endpackage

// File: rtl/attr_window_match.sv
module attr_window_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic          valid,
    output logic          hit
);
    // masked compare of the request address against the window base
    logic [AW-1:0] diff;

    always_comb begin
        diff = (addr ^ base) & mask;
        hit  = valid && (diff == '0);
    end
endmodule

// File: rtl/attr_prio_pick.sv
module attr_prio_pick #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic found;

    // lowest index wins
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = |req;
    end

    // R1: at most one window selected
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1: the grant is a requester and nothing below it requests
    p_grant_lowest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (((gnt & req) != '0) && (((gnt - N'(1)) & req) == '0)));
endmodule

// File: rtl/attr_resolver.sv
module attr_resolver
    import attr_pkg::*;
#(
    parameter int AW          = 32,
    parameter bit MMU_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_instr,
    input  logic                req_write,
    input  logic [1:0]          req_class,
    input  logic                req_super,
    input  logic                req_tas,
    input  logic [N_RAM*AW-1:0] ram_base,
    input  logic [N_RAM*AW-1:0] ram_mask,
    input  logic [N_RAM-1:0]    ram_valid,
    input  logic [N_RAM-1:0]    ram_wp,
    input  logic [N_ROM*AW-1:0] rom_base,
    input  logic [N_ROM*AW-1:0] rom_mask,
    input  logic [N_ROM-1:0]    rom_valid,
    input  logic [N_ACR*AW-1:0] acr_base,
    input  logic [N_ACR*AW-1:0] acr_mask,
    input  logic [N_ACR-1:0]    acr_valid,
    input  logic [N_ACR*2-1:0]  acr_cmode,
    input  logic [N_ACR-1:0]    acr_wp,
    input  logic                mmu_en,
    input  logic [AW-1:0]       mmu_base,
    input  logic [AW-1:0]       mmu_mask,
    input  logic                iack_mask,
    input  logic [1:0]          def_cmode,
    input  logic                def_wp,
    output logic                res_valid,
    output logic [AW-1:0]       res_addr,
    output logic [1:0]          res_cmode,
    output logic                res_wp,
    output logic [NWIN-1:0]     res_hit,
    output logic                res_fault,
    output logic                res_local_en
);
    localparam int HALF_ACR = N_ACR / 2;

    // ------------------------------------------------------------
    // window table
    // ------------------------------------------------------------
    logic [AW-1:0]   win_base [NWIN];
    logic [AW-1:0]   win_mask [NWIN];
    logic [NWIN-1:0] win_valid;
    logic [NWIN-1:0] raw_hit;

    always_comb begin
        win_base[IDX_MMU]  = mmu_base;
        win_mask[IDX_MMU]  = mmu_mask;
        win_valid[IDX_MMU] = MMU_PRESENT && mmu_en;
        for (int i = 0; i < N_RAM; i++) begin
            win_base[IDX_RAM0+i]  = ram_base[i*AW +: AW];
            win_mask[IDX_RAM0+i]  = ram_mask[i*AW +: AW];
            win_valid[IDX_RAM0+i] = ram_valid[i];
        end
        for (int i = 0; i < N_ROM; i++) begin
            win_base[IDX_ROM0+i]  = rom_base[i*AW +: AW];
            win_mask[IDX_ROM0+i]  = rom_mask[i*AW +: AW];
            win_valid[IDX_ROM0+i] = rom_valid[i];
        end
        for (int i = 0; i < N_ACR; i++) begin
            win_base[IDX_ACR0+i]  = acr_base[i*AW +: AW];
            win_mask[IDX_ACR0+i]  = acr_mask[i*AW +: AW];
            win_valid[IDX_ACR0+i] = acr_valid[i];
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        attr_window_match #(.AW(AW)) u_match (
            .addr  (req_addr),
            .base  (win_base[g]),
            .mask  (win_mask[g]),
            .valid (win_valid[g]),
            .hit   (raw_hit[g])
        );
    end

    // ------------------------------------------------------------
    // eligibility by access type
    // ------------------------------------------------------------
    logic [NWIN-1:0] elig;
    logic            is_normal;
    logic            may_local;

    always_comb begin
        is_normal = (req_class == CLS_NORMAL);
        may_local = ((req_class == CLS_IACK) || (req_class == CLS_EMU)) && !iack_mask;
        elig      = '0;
        if (is_normal) begin
            elig[IDX_MMU] = !req_instr;
            for (int i = 0; i < N_RAM + N_ROM; i++) elig[IDX_RAM0+i] = 1'b1;
            for (int i = 0; i < HALF_ACR; i++) begin
                if (req_instr) elig[IDX_ACR0+HALF_ACR+i] = 1'b1;
                else           elig[IDX_ACR0+i]          = 1'b1;
            end
        end else if (may_local) begin
            for (int i = 0; i < N_RAM + N_ROM; i++) elig[IDX_RAM0+i] = 1'b1;
        end
    end

    logic [NWIN-1:0] sel;
    logic            sel_any;

    attr_prio_pick #(.N(NWIN)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (raw_hit & elig),
        .gnt   (sel),
        .any   (sel_any)
    );

    // ------------------------------------------------------------
    // attribute merge
    // ------------------------------------------------------------
    logic [1:0] nxt_cmode;
    logic       nxt_wp;
    logic       nxt_fault;
    logic       nxt_local;
    logic       sel_ram;
    logic       sel_rom;
    logic       tas_implied;

    always_comb begin
        sel_ram     = |sel[IDX_RAM0 +: N_RAM];
        sel_rom     = |sel[IDX_ROM0 +: N_ROM];
        nxt_cmode   = def_cmode;
        nxt_wp      = def_wp;
        if (sel_any) begin
            if (sel[IDX_MMU]) begin
                nxt_cmode = CM_NC_PRECISE;
                nxt_wp    = 1'b0;
            end else if (sel_ram) begin
                nxt_cmode = CM_NC_PRECISE;
                nxt_wp    = |(sel[IDX_RAM0 +: N_RAM] & ram_wp);
            end else if (sel_rom) begin
                nxt_cmode = CM_NC_PRECISE;
                nxt_wp    = 1'b1;
            end else begin
                for (int i = 0; i < N_ACR; i++) begin
                    if (sel[IDX_ACR0+i]) begin
                        nxt_cmode = acr_cmode[2*i +: 2];
                        nxt_wp    = acr_wp[i];
                    end
                end
            end
        end
        tas_implied = is_normal && !req_instr && req_tas && !sel_ram;
        if (tas_implied) nxt_cmode = CM_NC_PRECISE;
        if (!is_normal) begin
            nxt_cmode = CM_NC_PRECISE;
            nxt_wp    = 1'b0;
        end
        nxt_fault = (sel[IDX_MMU] && !req_super) || (req_write && nxt_wp);
        nxt_local = (sel_ram || sel_rom) && !nxt_fault;
    end

    // ------------------------------------------------------------
    // result controller
    // ------------------------------------------------------------
    res_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)  state_d = ST_PRESENT;  // idle_to_present
            ST_PRESENT: if (!req_valid) state_d = ST_IDLE;     // present_to_idle, else present_stay
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_addr     <= '0;
            res_cmode    <= CM_COPYBACK;
            res_wp       <= 1'b0;
            res_hit      <= '0;
            res_fault    <= 1'b0;
            res_local_en <= 1'b0;
        end else if (req_valid) begin
            res_addr     <= req_addr;
            res_cmode    <= nxt_cmode;
            res_wp       <= nxt_wp;
            res_hit      <= sel;
            res_fault    <= nxt_fault;
            res_local_en <= nxt_local;
        end
    end

    assign res_valid = (state_q == ST_PRESENT);

    // ------------------------------------------------------------
    // checks
    // ------------------------------------------------------------
    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_cmode) && $stable(res_hit) && $stable(res_fault)));

    p_addr_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_addr == $past(req_addr)));

    p_special_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class != CLS_NORMAL) |=>
            (res_cmode == CM_NC_PRECISE && !res_wp && !res_fault
             && res_hit[IDX_MMU] == 1'b0 && res_hit[IDX_ACR0 +: N_ACR] == '0));

    p_instr_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_instr) |=>
            (!res_hit[IDX_MMU] && res_hit[IDX_ACR0 +: HALF_ACR] == '0));

    p_tas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_normal && !req_instr && req_tas && !sel_ram) |=>
            (res_cmode == CM_NC_PRECISE));

    p_mmu_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel[IDX_MMU] && !req_super) |=> res_fault);

    p_fault_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> !res_local_en);
endmodule

// File: tb/tb_attr_resolver.sv
`timescale 1ns/1ps
module tb_attr_resolver;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_instr = 1'b0;
    logic            req_write = 1'b0;
    logic [1:0]      req_class = 2'b00;
    logic            req_super = 1'b0;
    logic            req_tas = 1'b0;
    logic [2*AW-1:0] ram_base, ram_mask, rom_base, rom_mask;
    logic [1:0]      ram_valid, ram_wp, rom_valid;
    logic [4*AW-1:0] acr_base, acr_mask;
    logic [3:0]      acr_valid, acr_wp;
    logic [7:0]      acr_cmode;
    logic            mmu_en, iack_mask, def_wp;
    logic [AW-1:0]   mmu_base, mmu_mask;
    logic [1:0]      def_cmode;
    logic            res_valid, res_wp, res_fault, res_local_en;
    logic [AW-1:0]   res_addr;
    logic [1:0]      res_cmode;
    logic [8:0]      res_hit;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    attr_resolver #(.AW(AW), .MMU_PRESENT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_instr(req_instr), .req_write(req_write), .req_class(req_class),
        .req_super(req_super), .req_tas(req_tas),
        .ram_base(ram_base), .ram_mask(ram_mask), .ram_valid(ram_valid), .ram_wp(ram_wp),
        .rom_base(rom_base), .rom_mask(rom_mask), .rom_valid(rom_valid),
        .acr_base(acr_base), .acr_mask(acr_mask), .acr_valid(acr_valid),
        .acr_cmode(acr_cmode), .acr_wp(acr_wp),
        .mmu_en(mmu_en), .mmu_base(mmu_base), .mmu_mask(mmu_mask),
        .iack_mask(iack_mask), .def_cmode(def_cmode), .def_wp(def_wp),
        .res_valid(res_valid), .res_addr(res_addr), .res_cmode(res_cmode),
        .res_wp(res_wp), .res_hit(res_hit), .res_fault(res_fault),
        .res_local_en(res_local_en)
    );

    // {req tag, addr, instr, write, class, super, tas, exp cmode, exp wp, exp hit, exp fault, exp local}
    localparam int NV = 26;
    localparam logic [55:0] VEC [NV] = '{
        {4'd1,  32'h1000_0010, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b0,9'h001,1'b0,1'b0}, // R1 MMU over RAM0
        {4'd9,  32'h1000_0010, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,1'b0,9'h001,1'b1,1'b0}, // R9 user on MMU
        {4'd2,  32'h1000_0010, 1'b1,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b0,9'h002,1'b0,1'b1}, // R2 fetch skips MMU
        {4'd1,  32'h1000_4000, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b0,9'h002,1'b0,1'b1}, // R1 RAM0 over RAM1
        {4'd11, 32'h1000_4000, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,1'b0,9'h002,1'b0,1'b1}, // R11 user RAM0
        {4'd10, 32'h1001_0000, 1'b0,1'b1,2'd0,1'b1,1'b0, 2'd2,1'b1,9'h004,1'b1,1'b0}, // R10 write RAM1 wp
        {4'd10, 32'h1001_0000, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b1,9'h004,1'b0,1'b1}, // R10 read RAM1
        {4'd1,  32'h2000_0100, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b1,9'h008,1'b0,1'b1}, // R1 ROM0 over ROM1
        {4'd10, 32'h2000_0100, 1'b0,1'b1,2'd0,1'b1,1'b0, 2'd2,1'b1,9'h008,1'b1,1'b0}, // R10 ROM write
        {4'd1,  32'h2080_0000, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd2,1'b1,9'h010,1'b0,1'b1}, // R1 ROM1
        {4'd1,  32'h3000_0000, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd1,1'b0,9'h020,1'b0,1'b0}, // R1 ACR0 over ACR1
        {4'd10, 32'h2100_0000, 1'b0,1'b1,2'd0,1'b1,1'b0, 2'd0,1'b1,9'h040,1'b1,1'b0}, // R10 ACR1 write
        {4'd2,  32'h3000_0000, 1'b1,1'b0,2'd0,1'b1,1'b0, 2'd3,1'b0,9'h080,1'b0,1'b0}, // R2 ACR2
        {4'd2,  32'h4000_0000, 1'b1,1'b0,2'd0,1'b1,1'b0, 2'd0,1'b1,9'h100,1'b0,1'b0}, // R2 ACR3
        {4'd3,  32'h4000_0000, 1'b0,1'b0,2'd0,1'b1,1'b0, 2'd1,1'b0,9'h000,1'b0,1'b0}, // R3 data default
        {4'd2,  32'h2100_0000, 1'b1,1'b0,2'd0,1'b1,1'b0, 2'd1,1'b0,9'h000,1'b0,1'b0}, // R2 fetch ignores ACR1
        {4'd3,  32'h5000_0000, 1'b0,1'b1,2'd0,1'b1,1'b0, 2'd1,1'b0,9'h000,1'b0,1'b0}, // R3 default write
        {4'd5,  32'h2000_0100, 1'b0,1'b1,2'd3,1'b1,1'b0, 2'd2,1'b0,9'h000,1'b0,1'b0}, // R5 ctrl no hit
        {4'd5,  32'h1000_4000, 1'b0,1'b0,2'd1,1'b1,1'b0, 2'd2,1'b0,9'h002,1'b0,1'b1}, // R5 iack RAM0
        {4'd5,  32'h1001_0000, 1'b0,1'b1,2'd2,1'b1,1'b0, 2'd2,1'b0,9'h004,1'b0,1'b1}, // R5 emu write RAM1
        {4'd5,  32'h1000_0010, 1'b0,1'b0,2'd1,1'b0,1'b0, 2'd2,1'b0,9'h002,1'b0,1'b1}, // R5 iack skips MMU
        {4'd5,  32'h3000_0000, 1'b0,1'b0,2'd2,1'b1,1'b0, 2'd2,1'b0,9'h000,1'b0,1'b0}, // R5 emu skips ACR
        {4'd7,  32'h3000_0000, 1'b0,1'b1,2'd0,1'b1,1'b1, 2'd2,1'b0,9'h020,1'b0,1'b0}, // R7 TAS on ACR0
        {4'd7,  32'h2100_0000, 1'b0,1'b1,2'd0,1'b1,1'b1, 2'd2,1'b1,9'h040,1'b1,1'b0}, // R7 TAS keeps wp
        {4'd7,  32'h5000_0000, 1'b0,1'b0,2'd0,1'b1,1'b1, 2'd2,1'b0,9'h000,1'b0,1'b0}, // R7 TAS default
        {4'd7,  32'h3000_0000, 1'b1,1'b0,2'd0,1'b1,1'b1, 2'd3,1'b0,9'h080,1'b0,1'b0}  // R7 fetch ignores TAS
    };

    task automatic check(input int tag, input logic [1:0] ecm, input logic ewp,
                         input logic [8:0] ehit, input logic efault, input logic elocal,
                         input logic [AW-1:0] eaddr);
        n_checks++;
        if (res_valid !== 1'b1 || res_cmode !== ecm || res_wp !== ewp || res_hit !== ehit ||
            res_fault !== efault || res_local_en !== elocal || res_addr !== eaddr) begin
            n_fails++;
            $display("FAIL R%0d addr=%h: got v=%b cm=%b wp=%b hit=%h f=%b le=%b a=%h exp cm=%b wp=%b hit=%h f=%b le=%b a=%h",
                     tag, eaddr, res_valid, res_cmode, res_wp, res_hit, res_fault, res_local_en,
                     res_addr, ecm, ewp, ehit, efault, elocal, eaddr);
        end
    endtask

    // drive on a falling edge, captured at the next rising edge, sampled at the following falling edge
    task automatic run_req(input int tag, input logic [AW-1:0] a, input logic ins, input logic wr,
                           input logic [1:0] cls, input logic sup, input logic tas,
                           input logic [1:0] ecm, input logic ewp, input logic [8:0] ehit,
                           input logic efault, input logic elocal);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_instr = ins; req_write = wr;
        req_class = cls; req_super = sup; req_tas = tas;
        @(negedge clk);
        check(tag, ecm, ewp, ehit, efault, elocal, a);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        ram_base  = {32'h1000_0000, 32'h1000_0000};
        ram_mask  = {32'hFF00_0000, 32'hFFFF_0000};
        ram_valid = 2'b11;
        ram_wp    = 2'b10;
        rom_base  = {32'h2000_0000, 32'h2000_0000};
        rom_mask  = {32'hFF00_0000, 32'hFFF0_0000};
        rom_valid = 2'b11;
        acr_base  = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h3000_0000};
        acr_mask  = {32'hF000_0000, 32'hF000_0000, 32'hE000_0000, 32'hF000_0000};
        acr_valid = 4'hF;
        acr_cmode = {2'd0, 2'd3, 2'd0, 2'd1};
        acr_wp    = 4'b1010;
        mmu_en    = 1'b1;
        mmu_base  = 32'h1000_0000;
        mmu_mask  = 32'hFFFF_F000;
        iack_mask = 1'b0;
        def_cmode = 2'd1;
        def_wp    = 1'b0;

        repeat (3) @(negedge clk);
        // R12 reset state
        n_checks++;
        if (res_valid !== 1'b0 || res_cmode !== 2'd0 || res_hit !== 9'h0 || res_fault !== 1'b0 ||
            res_local_en !== 1'b0 || res_wp !== 1'b0 || res_addr !== '0) begin
            n_fails++;
            $display("FAIL R12 reset: got v=%b cm=%b hit=%h f=%b le=%b exp all zero",
                     res_valid, res_cmode, res_hit, res_fault, res_local_en);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_req(int'(VEC[i][55:52]), VEC[i][51:20], VEC[i][19], VEC[i][18], VEC[i][17:16],
                    VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11], VEC[i][10:2],
                    VEC[i][1], VEC[i][0]);
        end

        // R12 hold: no request, result regs unchanged, valid drops
        @(negedge clk);
        n_checks++;
        if (res_valid !== 1'b0 || res_cmode !== 2'd3 || res_hit !== 9'h080 || res_addr !== 32'h3000_0000) begin
            n_fails++;
            $display("FAIL R12 hold: got v=%b cm=%b hit=%h a=%h exp v=0 cm=11 hit=080 a=30000000",
                     res_valid, res_cmode, res_hit, res_addr);
        end

        // R6 mask blocks interrupt-ack and emulator hits only
        iack_mask = 1'b1;
        run_req(6, 32'h1000_4000, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 1'b0, 9'h000, 1'b0, 1'b0);
        run_req(6, 32'h2000_0100, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0, 9'h000, 1'b0, 1'b0);
        run_req(6, 32'h1000_4000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 9'h002, 1'b0, 1'b1);
        iack_mask = 1'b0;

        // R8 MMU window off when disabled; R9 no fault then
        mmu_en = 1'b0;
        run_req(8, 32'h1000_0010, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 9'h002, 1'b0, 1'b1);
        run_req(9, 32'h1000_0010, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 9'h002, 1'b0, 1'b1);
        mmu_en = 1'b1;

        // R4 cleared valid bit drops the window
        ram_valid = 2'b10;
        run_req(4, 32'h1000_4000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 9'h004, 1'b0, 1'b1);
        ram_valid = 2'b11;
        acr_valid = 4'b1110;
        run_req(4, 32'h3000_0000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 9'h040, 1'b0, 1'b0);
        acr_valid = 4'hF;

        // R13 and R12 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h5000_0004; req_instr = 1'b0; req_write = 1'b0;
        req_class = 2'd0; req_super = 1'b1; req_tas = 1'b0;
        @(negedge clk);
        check(13, 2'd1, 1'b0, 9'h000, 1'b0, 1'b0, 32'h5000_0004);
        req_addr = 32'h2000_0200;
        @(negedge clk);
        check(12, 2'd2, 1'b1, 9'h008, 1'b0, 1'b1, 32'h2000_0200);
        req_valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule